// File: doc/BRIEF.md
# Serial Configuration Loader with Latch Routing

This block takes configuration words of 24 bits from a three-wire serial port (serial clock, serial data, load strobe) and passes each word to one of four parallel configuration registers. The serial pins are treated as asynchronous to the system clock. Each pin goes through a two-flop synchronizer, and the bit clock and load strobe are edge-detected inside the system clock domain. Bits shift into a 24-bit register on every rising serial-clock edge, most-significant bit first.

On every rising edge of the load strobe, the two lowest bits of the shift register pick a destination. The upper 22 bits, the payload, are copied into that destination register. Each of the four payload registers appears in parallel on the outputs, together with the named fields that neighbouring logic decodes. A one-cycle update pulse and the destination code mark every load. A load to the initialization destination also rewrites the function register and emits a one-cycle counter-reset pulse.

Top module: `serial_cfg_router`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, all four payload registers, all field outputs, `upd_pulse_o`, `upd_dest_o` and `cnt_rst_o` are zero.
- R2: One bit is taken from `ser_dat_i` per rising edge of `ser_clk_i`. Falling edges shift nothing. The first bit sent ends up in word bit 23 and the last bit sent in word bit 0.
- R3: On a rising edge of `ser_le_i`, word bits [23:2] form the payload. Word bits [1:0] select the destination: 2'b00 reference register (`ref_word_o`), 2'b01 feedback register (`fb_word_o`), 2'b10 function register (`func_word_o`), 2'b11 initialization register (`init_word_o`).
- R4: A load leaves every register that it does not select unchanged.
- R5: A load with code 2'b11 writes its payload into both `init_word_o` and `func_word_o`, and raises `cnt_rst_o` for exactly that one cycle. Loads with other codes never raise `cnt_rst_o`.
- R6: Each rising edge of `ser_le_i` gives exactly one single-cycle `upd_pulse_o`. In that cycle `upd_dest_o` carries the 2-bit code, and the registers already show the new payload. Holding `ser_le_i` high produces no further pulses.
- R7: If a load arrives after fewer or more than 24 serial clocks, the payload and code are taken from the last 24 bits shifted in. With fewer than 24, the upper bits are those left from earlier traffic.
- R8: The field outputs are cut from the registers as follows. `ref_div_o` = reference payload [13:0]. `fb_a_o` = feedback payload [5:0]. `fb_b_o` = feedback payload [18:6]. `mux_sel_o` = function payload [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first, asynchronous |
| ser_le_i | input | 1 | Load strobe, rising edge loads, asynchronous |
| ref_word_o | output | 22 | Reference register payload |
| fb_word_o | output | 22 | Feedback register payload |
| func_word_o | output | 22 | Function register payload |
| init_word_o | output | 22 | Initialization register payload |
| ref_div_o | output | 14 | Reference divider field |
| fb_a_o | output | 6 | Feedback low counter field |
| fb_b_o | output | 13 | Feedback high counter field |
| mux_sel_o | output | 3 | Output multiplexer select field |
| upd_pulse_o | output | 1 | One-cycle pulse on every load |
| upd_dest_o | output | 2 | Destination code of the most recent load |
| cnt_rst_o | output | 1 | One-cycle counter reset on initialization loads |

## Verification
The hardest case to reach is a load whose word is partly stale. This happens when the strobe comes after too few or too many serial clocks, so that some of the routed bits are left over from an earlier word and the destination code is whatever happens to sit in the two lowest positions. The driver sends frames of 20 and 28 bits after full frames with known content. It keeps its own 24-bit shadow of the shift path and pushes the expected state of all four registers. The monitor compares every register at each update pulse. The same compare checks the dual write on initialization loads, and that registers not selected stay unchanged.

// File: rtl/cfg3w_pkg.sv
// Package: shared widths and destination codes for the serial config loader.
// Assumes: word layout is payload in the upper bits, code in the lowest bits.
package cfg3w_pkg;
    parameter int WORD_W    = 24;
    parameter int SEL_W     = 2;
    parameter int PAYLOAD_W = WORD_W - SEL_W;
    parameter int NUM_DEST  = 1 << SEL_W;
    parameter int REF_DIV_W = 14;
    parameter int FB_A_W    = 6;
    parameter int FB_B_W    = 13;
    parameter int MUX_W     = 3;
    parameter int SYNC_STG  = 2;

    typedef enum logic [SEL_W-1:0] {
        DEST_REF  = 2'b00,
        DEST_FB   = 2'b01,
        DEST_FUNC = 2'b10,
        DEST_INIT = 2'b11
    } dest_e;
endpackage

// File: rtl/cfg3w_sync.sv
// Module: multi-stage synchronizer with rising-edge detect, one lane per bit.
// Assumes: each input stays stable for at least two system clocks.
module cfg3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] prev_q;

    // Purpose: move the asynchronous pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    // Purpose: hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Purpose: expose the synchronized level and its rising edges.
    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = chain_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/cfg3w_shifter.sv
// Module: serial-in shift register, MSB first, one bit per bit-clock edge.
// Assumes: data level is synchronized with the same delay as the clock.
module cfg3w_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] sr_q;

    // Purpose: shift a new bit in at the low end on each detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
    end

    assign word_o = sr_q;
endmodule

// File: rtl/cfg3w_router.sv
// Module: decodes the code bits on a load and writes the chosen payload register.
// Assumes: load_i is a single-cycle pulse; the init code also rewrites function.
module cfg3w_router
    import cfg3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [WORD_W-1:0]    word_i,
    output logic [PAYLOAD_W-1:0] regs_o [NUM_DEST],
    output logic                 upd_o,
    output logic [SEL_W-1:0]     dest_o,
    output logic                 cnt_rst_o
);
    logic [SEL_W-1:0]     code;
    logic [PAYLOAD_W-1:0] payload;
    logic [NUM_DEST-1:0]  wr_en;

    // Purpose: split the word into code and payload.
    always_comb begin
        code    = word_i[SEL_W-1:0];
        payload = word_i[WORD_W-1:SEL_W];
    end

    genvar d;
    generate
        for (d = 0; d < NUM_DEST; d++) begin : g_dest
            // Purpose: write enable for this destination, init also hits function.
            always_comb begin
                wr_en[d] = load_i && ((code == SEL_W'(d)) ||
                           ((d == int'(DEST_FUNC)) && (code == DEST_INIT)));
            end
            // Purpose: payload register for this destination.
            always_ff @(posedge clk) begin
                if (!rst_n)        regs_o[d] <= '0;
                else if (wr_en[d]) regs_o[d] <= payload;
            end
        end
    endgenerate

    // Purpose: update strobe, destination code and counter-reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_o     <= 1'b0;
            dest_o    <= '0;
            cnt_rst_o <= 1'b0;
        end else begin
            upd_o     <= load_i;
            cnt_rst_o <= load_i && (code == DEST_INIT);
            if (load_i) dest_o <= code;
        end
    end
endmodule

// File: rtl/serial_cfg_router.sv
// Module: top of the three-wire configuration loader.
// Assumes: clk runs at least four times faster than ser_clk_i; pins asynchronous.
module serial_cfg_router
    import cfg3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk_i,
    input  logic                 ser_dat_i,
    input  logic                 ser_le_i,
    output logic [PAYLOAD_W-1:0] ref_word_o,
    output logic [PAYLOAD_W-1:0] fb_word_o,
    output logic [PAYLOAD_W-1:0] func_word_o,
    output logic [PAYLOAD_W-1:0] init_word_o,
    output logic [REF_DIV_W-1:0] ref_div_o,
    output logic [FB_A_W-1:0]    fb_a_o,
    output logic [FB_B_W-1:0]    fb_b_o,
    output logic [MUX_W-1:0]     mux_sel_o,
    output logic                 upd_pulse_o,
    output logic [SEL_W-1:0]     upd_dest_o,
    output logic                 cnt_rst_o
);
    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_LE  = 2;

    logic [2:0]           pin_lvl, pin_rise;
    logic [WORD_W-1:0]    word;
    logic [PAYLOAD_W-1:0] regs [NUM_DEST];

    cfg3w_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le_i, ser_dat_i, ser_clk_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    cfg3w_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (pin_rise[PIN_CLK]),
        .bit_i   (pin_lvl[PIN_DAT]),
        .word_o  (word)
    );

    cfg3w_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (pin_rise[PIN_LE]),
        .word_i    (word),
        .regs_o    (regs),
        .upd_o     (upd_pulse_o),
        .dest_o    (upd_dest_o),
        .cnt_rst_o (cnt_rst_o)
    );

    // Purpose: expose registers and the named fields neighbours decode.
    always_comb begin
        ref_word_o  = regs[DEST_REF];
        fb_word_o   = regs[DEST_FB];
        func_word_o = regs[DEST_FUNC];
        init_word_o = regs[DEST_INIT];
        ref_div_o   = ref_word_o[REF_DIV_W-1:0];
        fb_a_o      = fb_word_o[FB_A_W-1:0];
        fb_b_o      = fb_word_o[FB_A_W+FB_B_W-1:FB_A_W];
        mux_sel_o   = func_word_o[MUX_W-1:0];
    end
endmodule

// File: rtl/serial_cfg_router_chk.sv
// Module: property checker for the serial configuration loader, bound to the top.
// Assumes: observes ports only.
module serial_cfg_router_chk
    import cfg3w_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [PAYLOAD_W-1:0] ref_word_o,
    input logic [PAYLOAD_W-1:0] fb_word_o,
    input logic [PAYLOAD_W-1:0] func_word_o,
    input logic [PAYLOAD_W-1:0] init_word_o,
    input logic                 upd_pulse_o,
    input logic [SEL_W-1:0]     upd_dest_o,
    input logic                 cnt_rst_o
);
    // R6: update pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse_o |=> !upd_pulse_o);

    // R5: counter reset only with an init load
    a_r5_cnt_rst_init: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |-> (upd_pulse_o && upd_dest_o == 2'b11));

    // R5: init load mirrors into function register
    a_r5_init_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse_o && upd_dest_o == 2'b11) |-> (func_word_o == init_word_o));

    // R4: reference register holds unless selected
    a_r4_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_pulse_o && upd_dest_o == 2'b00) |-> $stable(ref_word_o));

    // R4: feedback register holds unless selected
    a_r4_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_pulse_o && upd_dest_o == 2'b01) |-> $stable(fb_word_o));

    // R4: function register holds unless function or init load
    a_r4_func_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_pulse_o && upd_dest_o[1]) |-> $stable(func_word_o));

    // R4: init register holds unless init load
    a_r4_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_pulse_o && upd_dest_o == 2'b11) |-> $stable(init_word_o));
endmodule

bind serial_cfg_router serial_cfg_router_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_word_o  (ref_word_o),
    .fb_word_o   (fb_word_o),
    .func_word_o (func_word_o),
    .init_word_o (init_word_o),
    .upd_pulse_o (upd_pulse_o),
    .upd_dest_o  (upd_dest_o),
    .cnt_rst_o   (cnt_rst_o)
);

// File: tb/serial_cfg_router_tb.sv
module serial_cfg_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    typedef struct packed {
        logic [1:0]  dest;
        logic [21:0] r_ref;
        logic [21:0] r_fb;
        logic [21:0] r_func;
        logic [21:0] r_init;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [21:0] ref_word, fb_word, func_word, init_word;
    logic [13:0] ref_div;
    logic [5:0]  fb_a;
    logic [12:0] fb_b;
    logic [2:0]  mux_sel;
    logic        upd_pulse, cnt_rst;
    logic [1:0]  upd_dest;

    int n_cmp = 0, n_bad = 0, n_pulse = 0, n_sent = 0;
    exp_t exp_q[$];
    logic [23:0] shadow = '0;
    logic [21:0] m_ref = '0, m_fb = '0, m_func = '0, m_init = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
        .ref_word_o(ref_word), .fb_word_o(fb_word),
        .func_word_o(func_word), .init_word_o(init_word),
        .ref_div_o(ref_div), .fb_a_o(fb_a), .fb_b_o(fb_b), .mux_sel_o(mux_sel),
        .upd_pulse_o(upd_pulse), .upd_dest_o(upd_dest), .cnt_rst_o(cnt_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Driver: send nbits of bits MSB first, pulse the load strobe, push expectation.
    task automatic send_word(input logic [31:0] bits, input int nbits, input int le_hold);
        exp_t e;
        logic [21:0] pl;
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_clk(HALF_BIT);
            ser_clk = 1'b1;
            wait_clk(HALF_BIT);
            ser_clk = 1'b0;
            shadow = {shadow[22:0], bits[i]};
        end
        pl = shadow[23:2];
        case (shadow[1:0])
            2'b00: m_ref = pl;
            2'b01: m_fb  = pl;
            2'b10: m_func = pl;
            default: begin m_func = pl; m_init = pl; end
        endcase
        e.dest = shadow[1:0];
        e.r_ref = m_ref; e.r_fb = m_fb; e.r_func = m_func; e.r_init = m_init;
        exp_q.push_back(e);
        n_sent++;
        wait_clk(HALF_BIT);
        ser_le = 1'b1;
        wait_clk(le_hold);
        ser_le = 1'b0;
        wait_clk(HALF_BIT * 2);
    endtask

    // Monitor: pop an expectation at each update pulse and compare everything.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && !upd_pulse && cnt_rst) chk("R5 cnt_rst without load", 32'(cnt_rst), 32'd0);
            if (rst_n && upd_pulse) begin
                n_pulse++;
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected update pulse", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R6 dest code", 32'(upd_dest), 32'(e.dest));
                    chk("R3/R4 ref register", 32'(ref_word), 32'(e.r_ref));
                    chk("R3/R4 fb register", 32'(fb_word), 32'(e.r_fb));
                    chk("R3/R4/R5 func register", 32'(func_word), 32'(e.r_func));
                    chk("R3/R4/R5 init register", 32'(init_word), 32'(e.r_init));
                    chk("R5 cnt_rst", 32'(cnt_rst), 32'(e.dest == 2'b11));
                    chk("R8 ref_div field", 32'(ref_div), 32'(e.r_ref[13:0]));
                    chk("R8 fb_a field", 32'(fb_a), 32'(e.r_fb[5:0]));
                    chk("R8 fb_b field", 32'(fb_b), 32'(e.r_fb[18:6]));
                    chk("R8 mux_sel field", 32'(mux_sel), 32'(e.r_func[2:0]));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait_clk(150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        @(negedge clk);
        // R1: reset state while held
        chk("R1 ref in reset", 32'(ref_word), 32'd0);
        chk("R1 fb in reset", 32'(fb_word), 32'd0);
        chk("R1 func in reset", 32'(func_word), 32'd0);
        chk("R1 init in reset", 32'(init_word), 32'd0);
        chk("R1 pulse in reset", {29'd0, upd_pulse, upd_dest}, 32'd0);
        chk("R1 cnt_rst in reset", 32'(cnt_rst), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {ref_word, upd_pulse, cnt_rst}, 32'd0);

        // R2/R3: one load to each destination with distinct patterns
        send_word({8'd0, 22'h2A5F31, 2'b00}, 24, 6);
        send_word({8'd0, 22'h15C3E7, 2'b01}, 24, 6);
        send_word({8'd0, 22'h3FFFFD, 2'b10}, 24, 6);
        send_word({8'd0, 22'h000006, 2'b10}, 24, 6);
        // R5: init load mirrors into function and pulses counter reset
        send_word({8'd0, 22'h1B2C3D, 2'b11}, 24, 6);
        send_word({8'd0, 22'h000000, 2'b00}, 24, 6);
        send_word({8'd0, 22'h3FFFFF, 2'b01}, 24, 6);
        // R6: long strobe gives one pulse only
        send_word({8'd0, 22'h0ABCDE, 2'b10}, 24, 60);
        // R7: short frame keeps stale upper bits, long frame keeps last 24
        send_word({12'd0, 20'hC35A1}, 20, 6);
        send_word({4'd0, 28'h9F0E3D2}, 28, 6);
        send_word({12'd0, 20'h7F00B}, 20, 6);
        send_word({8'd0, 22'h2468AC, 2'b11}, 24, 6);

        wait_clk(20);
        // R6: pulse count equals loads issued
        chk("R6 pulse count", 32'(n_pulse), 32'(n_sent));
        chk("R6 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule